// File: doc/BRIEF.md
# Thread Interrupt Priority Acknowledge Context

This block keeps the interrupt state of one hardware thread. The event queue side signals priorities through a set-pulse vector, and each pulse marks that priority as pending in a bitmap. The thread holds a current priority threshold. When the most urgent pending priority is numerically below that threshold, the block raises an interrupt line to the processor. A lower number is more urgent. Eight levels are used, and a threshold of 0xFF masks nothing.

Software uses a small byte-addressed register port. One offset holds the threshold, which can be read and written. A second offset holds a 16-bit acknowledge word, and reading it has side effects. When the read finds an eligible interrupt, it returns a source code of binary 10 in bits 15:14 and the accepted priority in the low byte. In the same step it clears that pending bit and raises the threshold to the accepted priority. Once the work is done, software writes the old threshold back so that less urgent levels can be delivered again.

Top module: `thread_prio_ack`

## Requirements
- R1: After reset the threshold is 0xFF, no priority is pending, and the interrupt line is low.
- R2: The interrupt line is high exactly when the lowest-numbered pending priority is numerically less than the threshold.
- R3: A read of offset 0x830 with an eligible interrupt returns bits 15:14 = 10, bits 13:8 = 0, and bits 7:0 = the lowest-numbered pending priority, in the same cycle as the read.
- R4: After an eligible acknowledge, the threshold equals the accepted priority on the next cycle and that priority's pending bit is cleared.
- R5: A read of offset 0x830 with nothing eligible returns 0x00FF (source field 00) and changes neither the threshold nor the pending bitmap.
- R6: If a priority's set pulse arrives in the same cycle that an acknowledge accepts that priority, the priority stays pending.
- R7: A write to offset 0x031 loads the low 8 bits of write data into the threshold, including values above 7. A read of 0x031 returns the threshold in bits 7:0 with bits 15:8 zero.
- R8: A write to any other offset has no effect, and a read of any other offset returns 0 with no side effect. Read data is 0 when no read is requested.
- R9: When read and write strobes are asserted together, only the write takes effect. The read returns 0 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_set | input | 8 | One-cycle set pulse per priority from the event queue side |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of rd_en |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions are checked on every cycle. They cover the agreement between the acknowledge source field and the interrupt line, the threshold moving to the returned priority after an accepted acknowledge, the threshold holding after an empty acknowledge, threshold writes, and a same-cycle set pulse surviving its own acknowledge. Other behaviours only show up in the bench's scenarios. These are the selection of the lowest-numbered priority among several pending ones, out-of-range threshold values, writes to unmapped offsets being ignored, the write-wins rule for simultaneous strobes, and the state after a reset in mid-operation.

// File: rtl/thread_prio_ack.sv
module thread_prio_ack #(
  parameter int NPRIO = 8,
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] CPPR_ADDR = 12'h031,
  parameter logic [AW-1:0] ACK_ADDR = 12'h830
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPRIO-1:0] pend_set,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] rdata,
  output logic            irq_out
);
  localparam int PW = $clog2(NPRIO);
  localparam logic [1:0] SRC_PHYS = 2'b10;
  localparam logic [DW-1:0] OPEN = {DW{1'b1}};

  logic [DW-1:0]    cppr_q, cppr_d;
  logic [NPRIO-1:0] pend_q, pend_d, clr;
  logic [PW-1:0]    best_idx;
  logic             best_vld;
  logic [DW-1:0]    best_prio;
  logic             eligible, do_rd, ack_hit, take;

  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    for (int i = NPRIO - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        best_vld = 1'b1;
        best_idx = i[PW-1:0];
      end
    end
  end

  assign best_prio = {{(DW-PW){1'b0}}, best_idx};
  assign eligible  = best_vld && (best_prio < cppr_q);
  assign do_rd     = rd_en && !wr_en;
  assign ack_hit   = do_rd && (addr == ACK_ADDR);
  assign take      = ack_hit && eligible;
  assign irq_out   = eligible;

  always_comb begin
    rdata = '0;
    if (do_rd && addr == CPPR_ADDR)
      rdata = {{DW{1'b0}}, cppr_q};
    else if (ack_hit)
      rdata = take ? {SRC_PHYS, {(DW-2){1'b0}}, best_prio} : {{DW{1'b0}}, OPEN};
  end

  assign clr    = take ? (NPRIO'(1) << best_idx) : '0;
  assign pend_d = (pend_q & ~clr) | pend_set;

  always_comb begin
    cppr_d = cppr_q;
    if (wr_en && addr == CPPR_ADDR)
      cppr_d = wdata;
    else if (take)
      cppr_d = best_prio;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= OPEN;
      pend_q <= '0;
    end else begin
      cppr_q <= cppr_d;
      pend_q <= pend_d;
    end
  end
endmodule

module thread_prio_ack_chk #(
  parameter int NPRIO = 8,
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] CPPR_ADDR = 12'h031,
  parameter logic [AW-1:0] ACK_ADDR = 12'h830
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPRIO-1:0] pend_set,
  input logic            rd_en,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [2*DW-1:0] rdata,
  input logic            irq_out,
  input logic [DW-1:0]   cppr_q,
  input logic [NPRIO-1:0] pend_q
);
  localparam int PW = $clog2(NPRIO);
  logic ack;
  assign ack = rd_en && !wr_en && addr == ACK_ADDR;

  assert_irq_needs_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q != '0 && cppr_q != '0));
  assert_ack_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((rdata[2*DW-1 -: 2] == 2'b10) == irq_out));
  assert_ack_moves_cppr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rdata[2*DW-1 -: 2] == 2'b10) |=> cppr_q == $past(rdata[DW-1:0]));
  assert_empty_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rdata[2*DW-1 -: 2] == 2'b00) |=> $stable(cppr_q));
  assert_set_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rdata[2*DW-1 -: 2] == 2'b10 && pend_set[rdata[PW-1:0]]) |=> pend_q[$past(rdata[PW-1:0])]);
  assert_cppr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CPPR_ADDR) |=> cppr_q == $past(wdata));
endmodule

bind thread_prio_ack thread_prio_ack_chk #(
  .NPRIO(NPRIO), .AW(AW), .DW(DW), .CPPR_ADDR(CPPR_ADDR), .ACK_ADDR(ACK_ADDR)
) u_chk (.*);

// File: tb/test_thread_prio_ack.sv
module test_thread_prio_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pend_set = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  thread_prio_ack i_thread_prio_ack (.*);

  // {pend_set, op(0 idle,1 rd,2 wr,3 both), addr, wdata, exp_rdata, exp_irq_after}
  localparam int NV = 20;
  localparam logic [46:0] VEC [NV] = '{
    {8'h20, 2'd0, 12'h000, 8'h00, 16'h0000, 1'b1}, // R2
    {8'h04, 2'd1, 12'h830, 8'h00, 16'h8005, 1'b1}, // R3 R4
    {8'h00, 2'd1, 12'h830, 8'h00, 16'h8002, 1'b0}, // R3 R4
    {8'h00, 2'd1, 12'h830, 8'h00, 16'h00FF, 1'b0}, // R5
    {8'h00, 2'd1, 12'h031, 8'h00, 16'h0002, 1'b0}, // R7
    {8'h00, 2'd2, 12'h031, 8'hFF, 16'h0000, 1'b0}, // R7
    {8'h81, 2'd0, 12'h000, 8'h00, 16'h0000, 1'b1}, // R2
    {8'h00, 2'd2, 12'h031, 8'h00, 16'h0000, 1'b0}, // R2
    {8'h00, 2'd1, 12'h830, 8'h00, 16'h00FF, 1'b0}, // R5
    {8'h00, 2'd2, 12'h031, 8'h07, 16'h0000, 1'b1}, // R2
    {8'h01, 2'd1, 12'h830, 8'h00, 16'h8000, 1'b0}, // R6
    {8'h00, 2'd2, 12'h031, 8'hFF, 16'h0000, 1'b1}, // R6
    {8'h00, 2'd1, 12'h830, 8'h00, 16'h8000, 1'b0}, // R6
    {8'h00, 2'd2, 12'h031, 8'h08, 16'h0000, 1'b1}, // R7
    {8'h00, 2'd2, 12'h032, 8'h00, 16'h0000, 1'b1}, // R8
    {8'h00, 2'd1, 12'h100, 8'h00, 16'h0000, 1'b1}, // R8
    {8'h00, 2'd3, 12'h830, 8'h00, 16'h0000, 1'b1}, // R9
    {8'h00, 2'd1, 12'h031, 8'h00, 16'h0008, 1'b1}, // R9
    {8'h00, 2'd1, 12'h830, 8'h00, 16'h8007, 1'b0}, // R3
    {8'h00, 2'd1, 12'h031, 8'h00, 16'h0007, 1'b0}  // R4
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_cppr(string req, logic [7:0] exp);
    @(negedge clk);
    rd_en = 1; addr = 12'h031;
    #1 check(req, rdata, {8'h00, exp});
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  initial begin
    #(5.0 * 5000);
    $display("FAIL watchdog actual=timeout expected=finish");
    fails++;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 irq", {15'd0, irq_out}, 16'd0);
    read_cppr("R1 cppr", 8'hFF);
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pend_set = VEC[v][46:39];
      rd_en = VEC[v][37];
      wr_en = VEC[v][38];
      addr = VEC[v][36:25];
      wdata = VEC[v][24:17];
      #1 check($sformatf("R2-7 vec%0d rdata", v), rdata, VEC[v][16:1]);
      @(posedge clk); #1;
      pend_set = '0; rd_en = 0; wr_en = 0;
      check($sformatf("R2 vec%0d irq", v), {15'd0, irq_out}, {15'd0, VEC[v][0]});
    end
    // R1: reset in mid-operation clears pending state and threshold
    @(negedge clk); pend_set = 8'h02;
    @(negedge clk); pend_set = '0;
    check("R2 pre-reset irq", {15'd0, irq_out}, 16'd1);
    rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    check("R1 irq after reset", {15'd0, irq_out}, 16'd0);
    read_cppr("R1 cppr after reset", 8'hFF);
    @(negedge clk); rd_en = 1; addr = 12'h830;
    #1 check("R1 R5 empty ack after reset", rdata, 16'h00FF);
    @(posedge clk); #1 rd_en = 0;
    // R8: idle read data is zero
    @(negedge clk); addr = 12'h031;
    #1 check("R8 idle rdata", rdata, 16'h0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule